// File: doc/BRIEF.md
# Soft-Stepping Amplifier Gain Controller

This block holds the gain code that is applied to a programmable-gain amplifier. It moves that code toward a programmed target. The code is a 7-bit value in half-decibel units, from 0 (0 dB) to 119 (59.5 dB). A separate mute state sits below code 0.

The block changes the applied gain only on a one-cycle step strobe that an external divider produces. When soft-stepping is enabled, each strobe moves the gain by one half-decibel step. When soft-stepping is disabled, the gain jumps to its destination on the next strobe.

Before the target is used, it is shifted by the input-resistance select and clamped to the legal range. A flag reports when the applied state matches the requested state. A powered-up flag stays high through a power-down until the ramp to mute has completed, so the step clock can be stopped safely only after that flag falls.

Top module: `pga_gain_stepper`

## Requirements
- R1: The applied gain code never exceeds 119. A target code above 119 is treated as 119.
- R2: With `soft_en` high and the amplifier unmuted, each `step_tick` moves `gain_code` exactly one code toward the effective target. When the gain is already on target, it holds.
- R3: After reset, `muted` is 1 and `gain_code` is 0.
- R4: With `soft_en` low, the first `step_tick` sets the applied state directly to the requested state. This means an immediate mute, or the effective target code.
- R5: `gain_reached` is 1 exactly when the applied state equals the requested state. That is either both muted, or both unmuted with `gain_code` equal to the effective target.
- R6: While `pga_en` is 0, the effective target is code 0 (0 dB, unmuted).
- R7: The resistance select shifts the target. `res_sel`=2'b01 adds 12 codes, clamped at 119. 2'b10 leaves the target unchanged. 2'b11 subtracts 12 codes, clamped at 0. 2'b00 requests mute.
- R8: Power-down (`pwr_req` low) requests mute. With soft-stepping on, the gain ramps down one code per tick to 0 and then enters mute on the following tick. `powered_up` is 1 whenever `pwr_req` is 1 or the amplifier is unmuted.
- R9: Without `step_tick`, `gain_code` and `muted` do not change. A target change in the middle of a ramp continues the ramp from the current applied code.
- R10: With soft-stepping on, leaving mute takes one tick to reach code 0, and the gain then ramps up from there. `mute_req` high also requests mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_code | input | 7 | Programmed gain code, 0.5 dB per LSB |
| pga_en | input | 1 | Amplifier enable; 0 forces 0 dB |
| mute_req | input | 1 | Mute request |
| soft_en | input | 1 | Soft-stepping enable |
| res_sel | input | 2 | Input-resistance select |
| pwr_req | input | 1 | Power-up request; 0 requests power-down |
| step_tick | input | 1 | One-cycle step strobe |
| gain_code | output | 7 | Applied gain code (0 while muted) |
| muted | output | 1 | Applied state is mute |
| gain_reached | output | 1 | Applied state equals requested state |
| powered_up | output | 1 | Amplifier still powered |

## Verification
A wrong applied code or mute bit appears on `gain_code` or `muted` in the first cycle after the tick that produced it. It also changes `gain_reached` at once, because that flag compares the stored state against the requested state. An error in the ramp direction or the step size shows up within one tick period. A mute sequencing fault shows up as `powered_up` falling before `gain_code` has reached 0. A reference model that steps alongside the design and is compared every clock catches each of these faults at its first divergent cycle.

// File: rtl/pga_gain_stepper.sv
module pga_gain_stepper #(
  parameter int CODE_W   = 7,
  parameter int MAX_CODE = 119,
  parameter int OFFSET   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] target_code,
  input  logic              pga_en,
  input  logic              mute_req,
  input  logic              soft_en,
  input  logic [1:0]        res_sel,
  input  logic              pwr_req,
  input  logic              step_tick,
  output logic [CODE_W-1:0] gain_code,
  output logic              muted,
  output logic              gain_reached,
  output logic              powered_up
);
  localparam int W = CODE_W + 1;
  localparam logic [W-1:0] MAXW = W'(MAX_CODE);
  localparam logic [W-1:0] OFFW = W'(OFFSET);

  logic [CODE_W-1:0] code_q;
  logic              mute_q;
  logic [W-1:0]      tgt_c, up_c, eff_w;
  logic [CODE_W-1:0] eff;
  logic              want_mute;

  assign tgt_c = ({1'b0, target_code} > MAXW) ? MAXW : {1'b0, target_code};
  assign up_c  = (tgt_c + OFFW > MAXW) ? MAXW : tgt_c + OFFW;

  always_comb begin
    case (res_sel)
      2'b01:   eff_w = up_c;
      2'b11:   eff_w = (tgt_c < OFFW) ? '0 : tgt_c - OFFW;
      default: eff_w = tgt_c;
    endcase
    if (!pga_en) eff_w = '0;
  end

  assign eff       = eff_w[CODE_W-1:0];
  assign want_mute = !pwr_req || mute_req || (res_sel == 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b1;
      code_q <= '0;
    end else if (step_tick) begin
      if (want_mute) begin
        if (!soft_en || code_q == '0) begin
          mute_q <= 1'b1;
          code_q <= '0;
        end else if (!mute_q) begin
          code_q <= code_q - 1'b1;
        end
      end else if (mute_q) begin
        mute_q <= 1'b0;
        code_q <= soft_en ? '0 : eff;
      end else if (!soft_en) begin
        code_q <= eff;
      end else if (code_q < eff) begin
        code_q <= code_q + 1'b1;
      end else if (code_q > eff) begin
        code_q <= code_q - 1'b1;
      end
    end
  end

  assign gain_code    = mute_q ? '0 : code_q;
  assign muted        = mute_q;
  assign gain_reached = want_mute ? mute_q : (!mute_q && code_q == eff);
  assign powered_up   = pwr_req || !mute_q;

  // R1
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code <= CODE_W'(MAX_CODE));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && soft_en && !muted && !want_mute) |=>
      (gain_code == $past(gain_code) || gain_code == $past(gain_code) + 1'b1 ||
       gain_code + 1'b1 == $past(gain_code)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> ($stable(gain_code) && $stable(muted)));

  // R8
  pwr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(powered_up) |-> (muted && gain_code == '0));

  // R10
  unmute_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(muted) && $past(soft_en)) |-> gain_code == '0);
endmodule

// File: tb/tb_pga_gain_stepper.sv
module tb_pga_gain_stepper;
  logic       clk = 0, rst_n = 0;
  logic [6:0] target_code = 0;
  logic       pga_en = 1, mute_req = 0, soft_en = 1, pwr_req = 0, step_tick = 0;
  logic [1:0] res_sel = 2'b10;
  logic [6:0] gain_code;
  logic       muted, gain_reached, powered_up;
  int vecs = 0, fails = 0, cyc = 0;
  int m_code = 0, m_mute = 1;

  pga_gain_stepper dut (.*);

  always #5 clk = ~clk;

  function automatic int eff_t();
    int t;
    t = (target_code > 119) ? 119 : int'(target_code);
    if (!pga_en) return 0;
    if (res_sel == 2'b01) t = (t + 12 > 119) ? 119 : t + 12;
    if (res_sel == 2'b11) t = (t < 12) ? 0 : t - 12;
    return t;
  endfunction

  function automatic bit want_m();
    return !pwr_req || mute_req || res_sel == 2'b00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_mute = 1; m_code = 0; end
    else if (step_tick) begin
      if (want_m()) begin
        if (!soft_en || m_code == 0) begin m_mute = 1; m_code = 0; end
        else if (!m_mute) m_code--;
      end else if (m_mute) begin
        m_mute = 0; m_code = soft_en ? 0 : eff_t();
      end else if (!soft_en) m_code = eff_t();
      else if (m_code < eff_t()) m_code++;
      else if (m_code > eff_t()) m_code--;
    end
  end

  task automatic check();
    int eg; bit er;
    eg = m_mute ? 0 : m_code;
    er = want_m() ? m_mute : (!m_mute && m_code == eff_t());
    vecs++;
    if (int'(gain_code) != eg) begin fails++; $display("FAIL R2 gain_code got %0d exp %0d t=%0t", gain_code, eg, $time); end
    if (muted != m_mute[0]) begin fails++; $display("FAIL R3 muted got %0b exp %0b t=%0t", muted, m_mute[0], $time); end
    if (gain_reached != er) begin fails++; $display("FAIL R5 gain_reached got %0b exp %0b t=%0t", gain_reached, er, $time); end
    if (powered_up != (pwr_req || !m_mute)) begin fails++; $display("FAIL R8 powered_up got %0b exp %0b t=%0t", powered_up, pwr_req || !m_mute, $time); end
  endtask

  task automatic run(int n, int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check();
      step_tick = (i % per) == per - 1;
    end
    @(negedge clk); check(); step_tick = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check();                                  // R3 reset state
    rst_n = 1;
    run(10, 1);                               // R9 ticks with mute held
    pwr_req = 1; target_code = 20; run(30, 2);   // R10, R2 ramp up
    target_code = 40; run(6, 3);              // R2 partial ramp
    target_code = 5; run(60, 2);              // R9 redirect mid-ramp
    soft_en = 0; target_code = 100; run(4, 2);   // R4 jump
    target_code = 127; run(4, 2);             // R1 clamp
    res_sel = 2'b01; target_code = 115; run(4, 2); // R7 +12 clamp
    res_sel = 2'b11; target_code = 5; run(4, 2);   // R7 -12 clamp
    target_code = 50; run(4, 2);              // R7 -12
    soft_en = 1; res_sel = 2'b01; run(40, 1); // R7 +12 soft
    pga_en = 0; run(80, 1);                   // R6 ramps to 0 dB
    pga_en = 1; run(20, 1);
    res_sel = 2'b00; run(40, 1);              // R7 mute select
    res_sel = 2'b10; target_code = 30; run(40, 1);
    mute_req = 1; run(40, 1);                 // R10 mute request
    mute_req = 0; run(40, 1);
    pwr_req = 0; run(80, 2);                  // R8 soft power-down ramp
    pwr_req = 1; soft_en = 0; run(4, 2);
    pwr_req = 0; run(4, 2);                   // R4 immediate mute
    pwr_req = 1; run(20, 7);                  // R9 sparse ticks
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule